// File: doc/BRIEF.md
# Indexed CMOS Clock Register File

This block is a PC-style battery-backed clock peripheral that a host reaches through two byte-wide I/O ports. The host first writes a register number to the index port and then reads or writes that register through the data port. Behind the ports sit a binary calendar (seconds through two-digit year), three alarm bytes, four status registers and a 114-byte scratch RAM. The current century is kept in BCD inside that RAM.

The calendar advances by one second on each pulse of `tick_1hz`, unless status B has frozen it. It is preset from the `preset_*` inputs while reset is held, and the century byte is preset the same way. The calendar is always held in binary. Each time field is converted when it is read. One status B bit chooses packed BCD or plain binary output, and another chooses 24-hour or 12-hour hours, where bit 7 of the hours value flags the afternoon. A host cannot write any time or date register.

Every access carries a byte count on `io_size`. Only single-byte accesses are accepted. A rejected access, or a forbidden status B value, raises `io_err` for one cycle and changes nothing. Read data appears on `io_rdata` one cycle after the read strobe and stays there until the next read.

Top module: `cmos_clock_regs`

## Requirements
- R1: A write to the index port (`io_port`=0) keeps only the low 7 bits of the data as the selected register number, so a write of 0x8B selects register 0x0B. A read of the index port returns 0xFF.
- R2: An access with `io_size` other than 1 raises `io_err` in the following cycle and changes no register, RAM byte or index.
- R3: Status B bit 2 selects the time output format: 1 gives binary and 0 gives packed BCD. Seconds are at 0x00, minutes at 0x02, hours at 0x04, weekday at 0x06 (reported 1–7 for internal 0–6), day at 0x07, month at 0x08 (1–12) and year at 0x09 (0–99).
- R4: Status B bit 1 set gives 24-hour hours. When it is clear, internal hour 0 reads 12, hours 13–23 read 1–11, and bit 7 of the hours byte is set for internal hours 12–23.
- R5: Each accepted tick adds one second. Seconds roll from 59 into minutes, minutes from 59 into hours, and hour 23 rolls to 0 while advancing the day and the weekday (6 wraps to 0).
- R6: The day rolls into the next month after the month's last day: 30 days for months 4, 6, 9 and 11, 31 for the others, and for February 29 days when the year is divisible by 4 and 28 otherwise. Month 12 rolls into the year, and year 99 wraps to 0.
- R7: While status B bit 7 is set, ticks do not change the time.
- R8: A write to status A (0x0A) stores the data with bit 7 forced to 0.
- R9: A write to status B (0x0B) with bit 6 set is rejected. It raises `io_err` and leaves status B unchanged.
- R10: Status C (0x0C) always reads 0x00. Status D (0x0D) always reads 0x80 and ignores writes.
- R11: Writes to registers 0x00, 0x02, 0x04 and 0x06–0x09 have no effect on the time.
- R12: The alarm bytes at 0x01, 0x03 and 0x05 read back exactly as written, with no format conversion.
- R13: Registers 0x0E–0x7F are read/write RAM. After reset they hold 0, except 0x32, which holds `preset_century`.
- R14: After reset the time equals the preset inputs, status A reads 0x00, status B reads 0x02 and the index is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; presets are captured while it is low |
| io_port | input | 1 | 0 selects the index port, 1 selects the data port |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_size | input | 3 | Access width in bytes; only 1 is accepted |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid from the cycle after a read |
| io_err | output | 1 | One-cycle pulse for a rejected access |
| tick_1hz | input | 1 | One-cycle pulse per second |
| preset_sec | input | 6 | Seconds preset, 0–59 |
| preset_min | input | 6 | Minutes preset, 0–59 |
| preset_hour | input | 5 | Hours preset, 0–23 |
| preset_wday | input | 3 | Weekday preset, 0–6 |
| preset_day | input | 5 | Day-of-month preset, 1–31 |
| preset_mon | input | 4 | Month preset, 1–12 |
| preset_year | input | 7 | Year preset, 0–99 |
| preset_century | input | 8 | BCD century written to RAM byte 0x32 at reset |

## Verification
Every cycle, the embedded assertions check that seconds and days stay within legal ranges, and that the time changes only on an accepted tick. They also check that a wrong-size access flags an error, that a forbidden status B write leaves status B untouched, and that index-port and status C reads return their fixed values. Only the bench's scenarios can show whether the values a host reads are correct. That covers the BCD, binary and 12-hour encodings, the carry chain from seconds to year, the month lengths and leap years, and the RAM and alarm contents.

// File: rtl/cmos_pkg.sv
package cmos_pkg;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] day;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_t;

    // binary 0..99 to packed two-digit BCD
    function automatic logic [7:0] bin2bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    // last day of a month; leap February when year is a multiple of four
    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] year);
        case (mon)
            4'd2:                    month_len = (year[1:0] == 2'd0) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: month_len = 5'd30;
            default:                 month_len = 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/cmos_calendar.sv
module cmos_calendar
    import cmos_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cal_t preset,
    input  logic advance,
    output cal_t cal
);

    cal_t cal_d, cal_q;

    always_comb begin
        cal_d = cal_q;
        if (advance) begin
            if (cal_q.sec == 6'd59) begin
                cal_d.sec = 6'd0;
                if (cal_q.min == 6'd59) begin
                    cal_d.min = 6'd0;
                    if (cal_q.hour == 5'd23) begin
                        cal_d.hour = 5'd0;
                        cal_d.wday = (cal_q.wday == 3'd6) ? 3'd0 : cal_q.wday + 3'd1;
                        if (cal_q.day >= month_len(cal_q.mon, cal_q.year)) begin
                            cal_d.day = 5'd1;
                            if (cal_q.mon == 4'd12) begin
                                cal_d.mon  = 4'd1;
                                cal_d.year = (cal_q.year == 7'd99) ? 7'd0 : cal_q.year + 7'd1;
                            end else begin
                                cal_d.mon = cal_q.mon + 4'd1;
                            end
                        end else begin
                            cal_d.day = cal_q.day + 5'd1;
                        end
                    end else begin
                        cal_d.hour = cal_q.hour + 5'd1;
                    end
                end else begin
                    cal_d.min = cal_q.min + 6'd1;
                end
            end else begin
                cal_d.sec = cal_q.sec + 6'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cal_q <= preset;
        else        cal_q <= cal_d;
    end

    assign cal = cal_q;

    // R7 / R11: time moves only on an accepted tick
    a_r11_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> cal_q == $past(cal_q));

    // R5: seconds stay legal
    a_r5_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
        cal_q.sec < 6'd60);

    // R6: day never passes the month's end
    a_r6_day_range: assert property (@(posedge clk) disable iff (!rst_n)
        cal_q.day != 5'd0 && cal_q.day <= month_len(cal_q.mon, cal_q.year));

endmodule

// File: rtl/cmos_fmt.sv
module cmos_fmt
    import cmos_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  cal_t             cal,
    input  logic [IDX_W-1:0] idx,
    input  logic             bin_mode,
    input  logic             mode_24h,
    output logic [7:0]       value
);

    localparam logic [IDX_W-1:0] SEC_IDX  = IDX_W'(0);
    localparam logic [IDX_W-1:0] MIN_IDX  = IDX_W'(2);
    localparam logic [IDX_W-1:0] HOUR_IDX = IDX_W'(4);
    localparam logic [IDX_W-1:0] WDAY_IDX = IDX_W'(6);
    localparam logic [IDX_W-1:0] DAY_IDX  = IDX_W'(7);
    localparam logic [IDX_W-1:0] MON_IDX  = IDX_W'(8);
    localparam logic [IDX_W-1:0] YEAR_IDX = IDX_W'(9);

    logic [4:0] hour_disp;
    logic [6:0] raw;
    logic       pm;

    always_comb begin
        if (mode_24h)               hour_disp = cal.hour;
        else if (cal.hour == 5'd0)  hour_disp = 5'd12;
        else if (cal.hour > 5'd12)  hour_disp = cal.hour - 5'd12;
        else                        hour_disp = cal.hour;
        pm = !mode_24h && (cal.hour >= 5'd12);
    end

    always_comb begin
        case (idx)
            SEC_IDX:  raw = 7'(cal.sec);
            MIN_IDX:  raw = 7'(cal.min);
            HOUR_IDX: raw = 7'(hour_disp);
            WDAY_IDX: raw = 7'(cal.wday) + 7'd1;
            DAY_IDX:  raw = 7'(cal.day);
            MON_IDX:  raw = 7'(cal.mon);
            YEAR_IDX: raw = cal.year;
            default:  raw = 7'd0;
        endcase
        value = bin_mode ? {1'b0, raw} : bin2bcd(raw);
        if (idx == HOUR_IDX && pm) value[7] = 1'b1;
    end

endmodule

// File: rtl/cmos_nvram.sv
module cmos_nvram #(
    parameter int DEPTH     = 114,
    parameter int AW        = 7,
    parameter int CENT_ADDR = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic [7:0]    century,
    output logic [7:0]    rdata
);

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];
    logic       in_range;

    assign in_range = int'(addr) < DEPTH;

    always_comb begin
        mem_d = mem_q;
        if (we && in_range) mem_d[addr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= (i == CENT_ADDR) ? century : 8'h00;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = in_range ? mem_q[addr] : 8'h00;

endmodule

// File: rtl/cmos_clock_regs.sv
module cmos_clock_regs
    import cmos_pkg::*;
#(
    parameter int IDX_W       = 7,
    parameter int RAM_BASE    = 14,
    parameter int CENTURY_IDX = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_port,
    input  logic       io_rd,
    input  logic       io_wr,
    input  logic [2:0] io_size,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    output logic       io_err,
    input  logic       tick_1hz,
    input  logic [5:0] preset_sec,
    input  logic [5:0] preset_min,
    input  logic [4:0] preset_hour,
    input  logic [2:0] preset_wday,
    input  logic [4:0] preset_day,
    input  logic [3:0] preset_mon,
    input  logic [6:0] preset_year,
    input  logic [7:0] preset_century
);

    localparam int RAM_DEPTH = (1 << IDX_W) - RAM_BASE;
    localparam int RAM_AW    = $clog2(RAM_DEPTH);
    localparam logic [IDX_W-1:0] IX_ALM_S = IDX_W'(1);
    localparam logic [IDX_W-1:0] IX_ALM_M = IDX_W'(3);
    localparam logic [IDX_W-1:0] IX_ALM_H = IDX_W'(5);
    localparam logic [IDX_W-1:0] IX_STA   = IDX_W'(10);
    localparam logic [IDX_W-1:0] IX_STB   = IDX_W'(11);
    localparam logic [IDX_W-1:0] IX_STC   = IDX_W'(12);
    localparam logic [IDX_W-1:0] IX_STD   = IDX_W'(13);
    localparam logic [IDX_W-1:0] IX_RAM   = IDX_W'(RAM_BASE);
    localparam int B_BIN  = 2;
    localparam int B_24H  = 1;
    localparam int B_PIE  = 6;
    localparam int B_HALT = 7;
    localparam logic [7:0] STB_RESET = 8'h02;
    localparam logic [7:0] STD_VALUE = 8'h80;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [7:0]       stat_a;
        logic [7:0]       stat_b;
        logic [7:0]       alm_s;
        logic [7:0]       alm_m;
        logic [7:0]       alm_h;
        logic [7:0]       rdata;
        logic             err;
    } regs_t;

    regs_t r_d, r_q;
    cal_t  preset, cal;
    logic  size_ok, access, advance, ram_we, is_ram;
    logic [7:0] fmt_val, ram_rdata, rd_mux;
    logic [RAM_AW-1:0] ram_addr;

    assign preset = '{year: preset_year, mon: preset_mon, day: preset_day,
                      wday: preset_wday, hour: preset_hour, min: preset_min,
                      sec: preset_sec};

    assign size_ok  = io_size == 3'd1;
    assign access   = io_rd || io_wr;
    assign advance  = tick_1hz && !r_q.stat_b[B_HALT];
    assign is_ram   = r_q.idx >= IX_RAM;
    assign ram_addr = RAM_AW'(r_q.idx - IX_RAM);
    assign ram_we   = io_wr && io_port && size_ok && is_ram;

    cmos_calendar u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (preset),
        .advance (advance),
        .cal     (cal)
    );

    cmos_fmt #(.IDX_W(IDX_W)) u_fmt (
        .cal      (cal),
        .idx      (r_q.idx),
        .bin_mode (r_q.stat_b[B_BIN]),
        .mode_24h (r_q.stat_b[B_24H]),
        .value    (fmt_val)
    );

    cmos_nvram #(
        .DEPTH     (RAM_DEPTH),
        .AW        (RAM_AW),
        .CENT_ADDR (CENTURY_IDX - RAM_BASE)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ram_we),
        .addr    (ram_addr),
        .wdata   (io_wdata),
        .century (preset_century),
        .rdata   (ram_rdata)
    );

    always_comb begin
        if (is_ram) begin
            rd_mux = ram_rdata;
        end else begin
            case (r_q.idx)
                IX_ALM_S: rd_mux = r_q.alm_s;
                IX_ALM_M: rd_mux = r_q.alm_m;
                IX_ALM_H: rd_mux = r_q.alm_h;
                IX_STA:   rd_mux = r_q.stat_a;
                IX_STB:   rd_mux = r_q.stat_b;
                IX_STC:   rd_mux = 8'h00;
                IX_STD:   rd_mux = STD_VALUE;
                default:  rd_mux = fmt_val;
            endcase
        end
    end

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        if (access && !size_ok) begin
            r_d.err = 1'b1;
        end else if (io_wr && !io_port) begin
            r_d.idx = io_wdata[IDX_W-1:0];
        end else if (io_wr) begin
            case (r_q.idx)
                IX_STA:   r_d.stat_a = io_wdata & 8'h7F;
                IX_STB: begin
                    if (io_wdata[B_PIE]) r_d.err = 1'b1;
                    else                 r_d.stat_b = io_wdata;
                end
                IX_ALM_S: r_d.alm_s = io_wdata;
                IX_ALM_M: r_d.alm_m = io_wdata;
                IX_ALM_H: r_d.alm_h = io_wdata;
                default:  ;
            endcase
        end else if (io_rd && !io_port) begin
            r_d.rdata = 8'hFF;
        end else if (io_rd) begin
            r_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{idx: '0, stat_a: 8'h00, stat_b: STB_RESET, alm_s: 8'h00,
                     alm_m: 8'h00, alm_h: 8'h00, rdata: 8'h00, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign io_rdata = r_q.rdata;
    assign io_err   = r_q.err;

    // R2: wrong-size access flags an error
    a_r2_size_err: assert property (@(posedge clk) disable iff (!rst_n)
        access && !size_ok |=> io_err);

    // R9: forbidden status B value leaves status B alone
    a_r9_pie_reject: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_port && size_ok && r_q.idx == IX_STB && io_wdata[B_PIE]
        |=> $stable(r_q.stat_b) && io_err);

    // R1: index port reads all ones
    a_r1_index_read: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && !io_wr && !io_port && size_ok |=> io_rdata == 8'hFF);

    // R10: status C reads zero
    a_r10_stat_c: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && !io_wr && io_port && size_ok && r_q.idx == IX_STC |=> io_rdata == 8'h00);

endmodule

// File: tb/test_cmos_clock_regs.sv
module test_cmos_clock_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_port = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
    logic [2:0] io_size = 3'd1;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       io_err;
    logic       tick_1hz = 1'b0;
    logic [5:0] p_sec = 6'd58, p_min = 6'd59;
    logic [4:0] p_hour = 5'd23, p_day = 5'd31;
    logic [2:0] p_wday = 3'd6;
    logic [3:0] p_mon = 4'd12;
    logic [6:0] p_year = 7'd99;
    logic [7:0] p_cent = 8'h20;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmos_clock_regs i_cmos_clock_regs (
        .clk(clk), .rst_n(rst_n), .io_port(io_port), .io_rd(io_rd), .io_wr(io_wr),
        .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_err(io_err),
        .tick_1hz(tick_1hz), .preset_sec(p_sec), .preset_min(p_min),
        .preset_hour(p_hour), .preset_wday(p_wday), .preset_day(p_day),
        .preset_mon(p_mon), .preset_year(p_year), .preset_century(p_cent)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int s, input int m, input int h, input int w,
                            input int d, input int mo, input int y);
        @(negedge clk);
        p_sec = 6'(s); p_min = 6'(m); p_hour = 5'(h); p_wday = 3'(w);
        p_day = 5'(d); p_mon = 4'(mo); p_year = 7'(y);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus(input logic port, input logic wr, input logic rd,
                       input logic [2:0] sz, input logic [7:0] d);
        @(negedge clk);
        io_port = port; io_wr = wr; io_rd = rd; io_size = sz; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0; io_size = 3'd1;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] v);
        bus(1'b0, 1'b1, 1'b0, 3'd1, idx);
        bus(1'b1, 1'b1, 1'b0, 3'd1, v);
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [7:0] v);
        bus(1'b0, 1'b1, 1'b0, 3'd1, idx);
        bus(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
        v = io_rdata;
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        do_reset(58, 59, 23, 6, 31, 12, 99);
        bus(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
        chk("R14 index 0 after reset (sec)", io_rdata, 8'h58);
        rd_reg(8'h0A, v); chk("R14 status A reset", v, 8'h00);
        rd_reg(8'h0B, v); chk("R14 status B reset", v, 8'h02);
        rd_reg(8'h0C, v); chk("R10 status C", v, 8'h00);
        rd_reg(8'h0D, v); chk("R10 status D", v, 8'h80);
        bus(1'b0, 1'b0, 1'b1, 3'd1, 8'h00);
        chk("R1 index port read", io_rdata, 8'hFF);
        rd_reg(8'h32, v); chk("R13 century preset", v, 8'h20);
        rd_reg(8'h0E, v); chk("R13 ram cleared", v, 8'h00);
    endtask

    task automatic t_bcd_fields();
        logic [7:0] v;
        rd_reg(8'h02, v); chk("R3 min bcd", v, 8'h59);
        rd_reg(8'h04, v); chk("R3 hour bcd", v, 8'h23);
        rd_reg(8'h06, v); chk("R3 wday 1-7", v, 8'h07);
        rd_reg(8'h07, v); chk("R3 day bcd", v, 8'h31);
        rd_reg(8'h08, v); chk("R3 month bcd", v, 8'h12);
        rd_reg(8'h09, v); chk("R3 year bcd", v, 8'h99);
    endtask

    task automatic t_rollover();
        logic [7:0] v;
        tick(); tick();
        rd_reg(8'h00, v); chk("R5 sec wrap", v, 8'h00);
        rd_reg(8'h02, v); chk("R5 min wrap", v, 8'h00);
        rd_reg(8'h04, v); chk("R5 hour wrap", v, 8'h00);
        rd_reg(8'h06, v); chk("R5 wday wrap", v, 8'h01);
        rd_reg(8'h07, v); chk("R6 day wrap", v, 8'h01);
        rd_reg(8'h08, v); chk("R6 month wrap", v, 8'h01);
        rd_reg(8'h09, v); chk("R6 year wrap", v, 8'h00);
    endtask

    task automatic t_month_len(input int d, input int mo, input int y,
                               input logic [7:0] ed, input logic [7:0] em, input string tag);
        logic [7:0] v;
        do_reset(59, 59, 23, 0, d, mo, y);
        tick();
        rd_reg(8'h07, v); chk({"R6 day ", tag}, v, ed);
        rd_reg(8'h08, v); chk({"R6 month ", tag}, v, em);
    endtask

    task automatic t_hours(input int h, input logic [7:0] stb, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        do_reset(0, 0, h, 0, 1, 1, 0);
        wr_reg(8'h0B, stb);
        rd_reg(8'h04, v); chk(tag, v, exp);
    endtask

    task automatic t_binary();
        logic [7:0] v;
        do_reset(58, 7, 23, 2, 15, 6, 42);
        wr_reg(8'h0B, 8'h06);
        rd_reg(8'h00, v); chk("R3 sec binary", v, 8'h3A);
        rd_reg(8'h04, v); chk("R4 hour 24h binary", v, 8'h17);
        rd_reg(8'h09, v); chk("R3 year binary", v, 8'h2A);
        rd_reg(8'h06, v); chk("R3 wday binary", v, 8'h03);
    endtask

    task automatic t_halt();
        logic [7:0] v;
        do_reset(58, 0, 1, 0, 1, 1, 0);
        wr_reg(8'h0B, 8'h82);
        tick(); tick();
        rd_reg(8'h00, v); chk("R7 halted sec", v, 8'h58);
        wr_reg(8'h0B, 8'h02);
        tick();
        rd_reg(8'h00, v); chk("R7 resumed sec", v, 8'h59);
    endtask

    task automatic t_writes();
        logic [7:0] v;
        do_reset(30, 20, 10, 3, 5, 5, 5);
        wr_reg(8'h00, 8'h11); wr_reg(8'h04, 8'h02); wr_reg(8'h09, 8'h77);
        rd_reg(8'h00, v); chk("R11 sec write ignored", v, 8'h30);
        rd_reg(8'h04, v); chk("R11 hour write ignored", v, 8'h10);
        rd_reg(8'h09, v); chk("R11 year write ignored", v, 8'h05);
        wr_reg(8'h0A, 8'hFF);
        rd_reg(8'h0A, v); chk("R8 status A bit7 cleared", v, 8'h7F);
        wr_reg(8'h0D, 8'h00);
        rd_reg(8'h0D, v); chk("R10 status D write ignored", v, 8'h80);
        wr_reg(8'h01, 8'h3C); wr_reg(8'h03, 8'hA5); wr_reg(8'h05, 8'h99);
        rd_reg(8'h01, v); chk("R12 alarm sec raw", v, 8'h3C);
        rd_reg(8'h03, v); chk("R12 alarm min raw", v, 8'hA5);
        rd_reg(8'h05, v); chk("R12 alarm hour raw", v, 8'h99);
        wr_reg(8'h0E, 8'h33); wr_reg(8'h7F, 8'hC4);
        rd_reg(8'h0E, v); chk("R13 ram low", v, 8'h33);
        rd_reg(8'h7F, v); chk("R13 ram high", v, 8'hC4);
    endtask

    task automatic t_rejects();
        logic [7:0] v;
        bus(1'b0, 1'b1, 1'b0, 3'd1, 8'h0B);
        bus(1'b1, 1'b1, 1'b0, 3'd1, 8'h46);
        total++; if (io_err !== 1'b1) begin bad++; $display("FAIL R9 err: actual=%b expected=1", io_err); end
        rd_reg(8'h0B, v); chk("R9 status B kept", v, 8'h02);
        bus(1'b0, 1'b1, 1'b0, 3'd1, 8'h0E);
        bus(1'b0, 1'b1, 1'b0, 3'd2, 8'h0A);
        total++; if (io_err !== 1'b1) begin bad++; $display("FAIL R2 err: actual=%b expected=1", io_err); end
        bus(1'b1, 1'b1, 1'b0, 3'd4, 8'h55);
        bus(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
        chk("R2 bad size no effect", io_rdata, 8'h33);
        bus(1'b0, 1'b1, 1'b0, 3'd1, 8'h8B);
        bus(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
        chk("R1 index masked to 0x0B", io_rdata, 8'h02);
    endtask

    initial begin
        t_reset_state();
        t_bcd_fields();
        t_rollover();
        t_month_len(28, 2, 24, 8'h29, 8'h02, "leap feb");
        t_month_len(28, 2, 23, 8'h01, 8'h03, "plain feb");
        t_month_len(30, 4, 23, 8'h01, 8'h05, "april");
        t_month_len(30, 1, 23, 8'h31, 8'h01, "january");
        t_hours(0,  8'h00, 8'h12, "R4 midnight 12h");
        t_hours(13, 8'h00, 8'h81, "R4 13h as 1pm bcd");
        t_hours(12, 8'h00, 8'h92, "R4 noon 12h");
        t_hours(13, 8'h04, 8'h81, "R4 13h 12h binary");
        t_hours(11, 8'h00, 8'h11, "R4 11am 12h");
        t_binary();
        t_halt();
        t_writes();
        t_rejects();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule